// File: doc/BRIEF.md
# Timer Compare and Capture Unit

A single timer channel built around a 32-bit free-running up-counter. A programmable divider produces a one-clock tick every (prescale+1) clocks, and the counter advances only on that tick. A reference register, loaded by software, is compared with the counter. A match is taken when the counter already holds the reference value and the next tick arrives. A match can restart the counter from zero. A chosen edge on an external input pin copies the live count into a capture register, which software can only read. Both events set sticky flags that software clears by writing ones.

Software reaches four registers through a two-bit index. Writes are single-cycle strobes. The read data is combinational on the index. In the alternative count-source mode, the synchronized rising edges of the input pin advance the counter in place of the divider. Captures are then suppressed, because one pin cannot be both the count source and the capture source.

Top module: `tcc_unit`

## Requirements
- R1: Register index 0 is MODE, 1 is REF, 2 is CAP and 3 is CNT. After reset MODE reads 0, REF reads 0xFFFFFFFF, CAP reads 0, CNT reads 0, and both flags are low.
- R2: The MODE field [15:8] sets the divider value P. The counter advances once every P+1 clocks. If P is lowered below the clocks already elapsed, the tick comes on the next clock.
- R3: When a tick arrives while CNT equals REF, the match flag (MODE[16], match_flag_o) sets at that clock edge. Counting from a cleared counter, this happens (REF+1)*(P+1) clocks after the clear.
- R4: With MODE[2] set, a match loads the counter with 0 instead of incrementing it. With MODE[2] clear, the counter keeps counting and wraps from 0xFFFFFFFF to 0.
- R5: MODE[1:0] selects the capture edge: 0 none, 1 rising, 2 falling, 3 both. On a selected edge, CAP takes the counter value and the capture flag (MODE[17], capture_flag_o) sets.
- R6: The pin passes through two synchronizer flops. Take A as the first clock edge that samples a new pin level. CAP then loads, at edge A+2, the count held between edges A+1 and A+2.
- R7: Writes to CAP have no effect.
- R8: Writing MODE with bit 16 or bit 17 set clears that flag. Without a clear, a flag stays set. An event in the same cycle as its clear leaves the flag set.
- R9: Any write to CNT zeroes the counter and restarts the divider, whatever the data.
- R10: With MODE[3] set, each synchronized rising edge of the pin advances the counter and the divider is bypassed. No capture occurs in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 1 | External capture / count-source pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe, one cycle |
| reg_idx_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_idx_i, combinational |
| match_flag_o | output | 1 | Sticky compare-match flag |
| capture_flag_o | output | 1 | Sticky capture flag |

## Verification
A register write takes effect at the clock edge that samples the strobe. A match or the counter step it triggers appears at the edge where the tick is taken. A capture lands two edges after the first synchronizer stage samples the pin. The bench drives all inputs at the falling edge and steps a cycle-level model at each rising edge. It compares the flags and register reads half a cycle later, so every expected value refers to the edge just passed. The directed cases count edges explicitly: the (REF+1)*(P+1) delay to a match, and the A+1 / A+2 window of a capture.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    IDX_MODE = 2'd0,
    IDX_REF  = 2'd1,
    IDX_CAP  = 2'd2,
    IDX_CNT  = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;

  localparam int unsigned MODE_EDGE_LSB    = 0;
  localparam int unsigned MODE_RESTART_BIT = 2;
  localparam int unsigned MODE_EXTCLK_BIT  = 3;
  localparam int unsigned MODE_PRE_LSB     = 8;
  localparam int unsigned MODE_MFLAG_BIT   = 16;
  localparam int unsigned MODE_CFLAG_BIT   = 17;

endpackage

// File: rtl/tcc_prescaler.sv
module tcc_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;

  // >= so that lowering div below the elapsed count ticks at once
  assign tick_o = !restart_i && (pre_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (restart_i || tick_o) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // st_q[STAGES-1] is the synchronized level, st_q[STAGES] its previous value
  logic [STAGES:0] st_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= 1'b0;
        else         st_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= 1'b0;
        else         st_q[g] <= st_q[g-1];
      end
    end
  end

  assign rise_o =  st_q[STAGES-1] && !st_q[STAGES];
  assign fall_o = !st_q[STAGES-1] &&  st_q[STAGES];

endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             restart_en_i,
  input  logic [CNT_W-1:0] ref_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_q;

  assign match_o = adv_i && !clr_i && (cnt_q == ref_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (match_o && restart_en_i) cnt_q <= '0;
    else if (adv_i)                   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tcc_capture.sv
module tcc_capture
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cap_edge_e        edge_sel_i,
  input  logic             block_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_ev_o
);

  logic want_rise, want_fall;
  logic [CNT_W-1:0] cap_q;

  assign want_rise = (edge_sel_i == EDGE_RISE) || (edge_sel_i == EDGE_BOTH);
  assign want_fall = (edge_sel_i == EDGE_FALL) || (edge_sel_i == EDGE_BOTH);
  assign cap_ev_o  = !block_i && ((want_rise && rise_i) || (want_fall && fall_i));
  assign cap_o     = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (cap_ev_o) cap_q <= cnt_i;
  end

endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_pin_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_idx_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             match_flag_o,
  output logic             capture_flag_o
);

  localparam logic [CNT_W-1:0] REF_RST = {CNT_W{1'b1}};

  reg_idx_e idx;
  logic wr_mode, wr_ref, wr_cnt;

  cap_edge_e        edge_q;
  logic             restart_q, ext_q;
  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] ref_q;
  logic             mflag_q, cflag_q;

  logic             pre_tick, pin_rise, pin_fall, adv;
  logic [CNT_W-1:0] cnt_val, cap_val;
  logic             match_ev, cap_ev;
  logic [CNT_W-1:0] mode_rd;

  assign idx     = reg_idx_e'(reg_idx_i);
  assign wr_mode = reg_we_i && (idx == IDX_MODE);
  assign wr_ref  = reg_we_i && (idx == IDX_REF);
  assign wr_cnt  = reg_we_i && (idx == IDX_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q    <= EDGE_OFF;
      restart_q <= 1'b0;
      ext_q     <= 1'b0;
      div_q     <= '0;
    end else if (wr_mode) begin
      edge_q    <= cap_edge_e'(reg_wdata_i[MODE_EDGE_LSB +: 2]);
      restart_q <= reg_wdata_i[MODE_RESTART_BIT];
      ext_q     <= reg_wdata_i[MODE_EXTCLK_BIT];
      div_q     <= reg_wdata_i[MODE_PRE_LSB +: PRE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= REF_RST;
    else if (wr_ref) ref_q <= reg_wdata_i;
  end

  // sticky flags: event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mflag_q <= 1'b0;
      cflag_q <= 1'b0;
    end else begin
      mflag_q <= match_ev || (mflag_q && !(wr_mode && reg_wdata_i[MODE_MFLAG_BIT]));
      cflag_q <= cap_ev   || (cflag_q && !(wr_mode && reg_wdata_i[MODE_CFLAG_BIT]));
    end
  end

  tcc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_cnt),
    .div_i     (div_q),
    .tick_o    (pre_tick)
  );

  tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign adv = ext_q ? pin_rise : pre_tick;

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (wr_cnt),
    .adv_i        (adv),
    .restart_en_i (restart_q),
    .ref_i        (ref_q),
    .cnt_o        (cnt_val),
    .match_o      (match_ev)
  );

  tcc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_sel_i (edge_q),
    .block_i    (ext_q),
    .rise_i     (pin_rise),
    .fall_i     (pin_fall),
    .cnt_i      (cnt_val),
    .cap_o      (cap_val),
    .cap_ev_o   (cap_ev)
  );

  always_comb begin
    mode_rd                             = '0;
    mode_rd[MODE_EDGE_LSB +: 2]         = edge_q;
    mode_rd[MODE_RESTART_BIT]           = restart_q;
    mode_rd[MODE_EXTCLK_BIT]            = ext_q;
    mode_rd[MODE_PRE_LSB +: PRE_W]      = div_q;
    mode_rd[MODE_MFLAG_BIT]             = mflag_q;
    mode_rd[MODE_CFLAG_BIT]             = cflag_q;
  end

  always_comb begin
    unique case (idx)
      IDX_MODE: reg_rdata_o = mode_rd;
      IDX_REF:  reg_rdata_o = ref_q;
      IDX_CAP:  reg_rdata_o = cap_val;
      default:  reg_rdata_o = cnt_val;
    endcase
  end

  assign match_flag_o   = mflag_q;
  assign capture_flag_o = cflag_q;

endmodule

// File: rtl/tcc_unit_chk.sv
module tcc_unit_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_idx_i,
  input logic [CNT_W-1:0] reg_wdata_i,
  input logic             match_flag_o,
  input logic             capture_flag_o,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cap_val,
  input logic             adv,
  input logic             match_ev,
  input logic             cap_ev,
  input logic             ext_q,
  input logic             restart_q
);

  logic cnt_wr, mclr_wr;
  assign cnt_wr  = reg_we_i && (reg_idx_i == 2'd3);
  assign mclr_wr = reg_we_i && (reg_idx_i == 2'd0) && reg_wdata_i[16];

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv && !cnt_wr) |=> $stable(cnt_val)); // R2

  AST_MATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_ev |=> match_flag_o); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_ev && restart_q) |=> (cnt_val == '0)); // R4

  AST_CAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> capture_flag_o); // R5

  AST_CAP_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_ev |=> $stable(cap_val)); // R7

  AST_MFLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclr_wr && !match_ev) |=> !match_flag_o); // R8

  AST_MFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !mclr_wr) |=> match_flag_o); // R8

  AST_CNT_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt_val == '0)); // R9

  AST_EXT_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> !cap_ev); // R10

endmodule

bind tcc_unit tcc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_idx_i      (reg_idx_i),
  .reg_wdata_i    (reg_wdata_i),
  .match_flag_o   (match_flag_o),
  .capture_flag_o (capture_flag_o),
  .cnt_val        (cnt_val),
  .cap_val        (cap_val),
  .adv            (adv),
  .match_ev       (match_ev),
  .cap_ev         (cap_ev),
  .ext_q          (ext_q),
  .restart_q      (restart_q)
);

// File: tb/tcc_unit_test.sv
`timescale 1ns/1ps
module tcc_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  idx = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mflag, cflag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit flag_chk_on = 1'b0;

  always #5 clk = ~clk;

  tcc_unit uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cap_pin_i      (pin),
    .reg_we_i       (we),
    .reg_idx_i      (idx),
    .reg_wdata_i    (wdata),
    .reg_rdata_o    (rdata),
    .match_flag_o   (mflag),
    .capture_flag_o (cflag)
  );

  // ---------------- reference model ----------------
  bit [7:0]  m_pre, m_div;
  bit [31:0] m_cnt, m_ref, m_cap;
  bit [1:0]  m_edge;
  bit        m_rst_mode, m_ext, m_mf, m_cf;
  bit [2:0]  m_sh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = '0; m_div = '0; m_cnt = '0; m_ref = 32'hFFFF_FFFF; m_cap = '0;
      m_edge = '0; m_rst_mode = 1'b0; m_ext = 1'b0; m_mf = 1'b0; m_cf = 1'b0;
      m_sh = '0;
    end else begin
      bit clr, tick, rise, fall, adv, match, caph, wmode;
      clr   = we && (idx == 2'd3);
      wmode = we && (idx == 2'd0);
      tick  = !clr && (m_pre >= m_div);
      rise  =  m_sh[1] && !m_sh[2];
      fall  = !m_sh[1] &&  m_sh[2];
      adv   = m_ext ? rise : tick;
      match = adv && !clr && (m_cnt == m_ref);
      caph  = !m_ext && ((m_edge[0] && rise) || (m_edge[1] && fall));
      if (caph) m_cap = m_cnt;
      m_pre = (clr || tick) ? 8'd0 : m_pre + 8'd1;
      if (clr) m_cnt = '0;
      else if (match && m_rst_mode) m_cnt = '0;
      else if (adv) m_cnt = m_cnt + 32'd1;
      m_mf = match || (m_mf && !(wmode && wdata[16]));
      m_cf = caph  || (m_cf && !(wmode && wdata[17]));
      if (wmode) begin
        m_edge = wdata[1:0]; m_rst_mode = wdata[2]; m_ext = wdata[3]; m_div = wdata[15:8];
      end
      if (we && idx == 2'd1) m_ref = wdata;
      m_sh = {m_sh[1:0], pin};
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] i);
    case (i)
      2'd0:    return {14'd0, m_cf, m_mf, m_div, 4'd0, m_ext, m_rst_mode, m_edge};
      2'd1:    return m_ref;
      2'd2:    return m_cap;
      default: return m_cnt;
    endcase
  endfunction

  function automatic logic [31:0] mode_w(input logic [1:0] e, input bit rs, input bit ex,
                                         input logic [7:0] dv, input bit mc, input bit cc);
    return {14'd0, cc, mc, dv, 4'd0, ex, rs, e};
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    we = 1'b1; idx = i; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] i, output logic [31:0] d);
    idx = i; #1; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] i, input logic [31:0] exp);
    logic [31:0] v;
    rd(i, v);
    check(req, v, exp);
  endtask

  // flags against the model every cycle
  always @(negedge clk) begin
    if (rst_n && flag_chk_on) begin
      check("R3 match flag", {31'd0, mflag}, {31'd0, m_mf});
      check("R5 capture flag", {31'd0, cflag}, {31'd0, m_cf});
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, oldcap;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values before any clock edge
    rd_chk("R1 MODE reset", 2'd0, 32'h0);
    rd_chk("R1 REF reset",  2'd1, 32'hFFFF_FFFF);
    rd_chk("R1 CAP reset",  2'd2, 32'h0);
    rd_chk("R1 CNT reset",  2'd3, 32'h0);
    check("R1 flags reset", {30'd0, mflag, cflag}, 32'h0);
    flag_chk_on = 1'b1;

    // R3 + R2: match after (REF+1)*(P+1) clocks
    wr(2'd1, 32'd5);
    wr(2'd0, mode_w(2'd0, 0, 0, 8'd2, 1, 1));
    wr(2'd3, 32'h0);
    n = 0;
    for (int k = 1; k <= 40 && n == 0; k++) begin
      steps(1);
      if (mflag) n = k;
    end
    check("R3 match delay", n, 18);

    // R8: clear with no competing event
    wr(2'd0, mode_w(2'd0, 0, 0, 8'd2, 1, 0));
    check("R8 flag cleared", {31'd0, mflag}, 32'd0);

    // R8: event in the clearing cycle wins (REF=0, restart => match every tick)
    wr(2'd1, 32'd0);
    wr(2'd0, mode_w(2'd0, 1, 0, 8'd0, 0, 0));
    wr(2'd3, 32'h0);
    steps(2);
    wr(2'd0, mode_w(2'd0, 1, 0, 8'd0, 1, 0));
    check("R8 event beats clear", {31'd0, mflag}, 32'd1);

    // R4: restart on match
    wr(2'd1, 32'd3);
    wr(2'd3, 32'h0);
    steps(4);
    rd_chk("R4 restart to zero", 2'd3, 32'd0);
    steps(1);
    rd_chk("R4 counts after restart", 2'd3, 32'd1);
    wr(2'd0, mode_w(2'd0, 0, 0, 8'd0, 1, 1));
    wr(2'd3, 32'h0);
    steps(4);
    rd_chk("R4 free run past match", 2'd3, 32'd4);

    // R2: divider 3 and restart by CNT write (R9 with odd data)
    wr(2'd0, mode_w(2'd0, 0, 0, 8'd3, 0, 0));
    wr(2'd3, 32'hDEAD_BEEF);
    rd_chk("R9 CNT write zeroes", 2'd3, 32'd0);
    steps(7);
    rd_chk("R2 one step after 7 clocks", 2'd3, 32'd1);
    steps(1);
    rd_chk("R2 two steps after 8 clocks", 2'd3, 32'd2);

    // R5/R6: rising-edge capture timing
    wr(2'd0, mode_w(2'd1, 0, 0, 8'd0, 1, 1));
    rd(2'd2, oldcap);
    pin = 1'b1;
    steps(2);                       // edges A, A+1
    rd(2'd3, v);
    rd_chk("R6 CAP not yet loaded", 2'd2, oldcap);
    steps(1);                       // edge A+2
    rd_chk("R6 CAP loaded at A+2", 2'd2, v);
    check("R5 capture flag set", {31'd0, cflag}, 32'd1);
    rd(2'd2, oldcap);
    pin = 1'b0;
    steps(4);
    rd_chk("R5 falling ignored in rise mode", 2'd2, oldcap);

    // R5: falling edge selection
    pin = 1'b1;
    steps(4);
    wr(2'd0, mode_w(2'd2, 0, 0, 8'd0, 0, 1));
    pin = 1'b0;
    steps(2);
    rd(2'd3, v);
    steps(1);
    rd_chk("R5 falling capture", 2'd2, v);

    // R5: edge selection off
    wr(2'd0, mode_w(2'd0, 0, 0, 8'd0, 0, 1));
    rd(2'd2, oldcap);
    pin = 1'b1; steps(3); pin = 1'b0; steps(3);
    rd_chk("R5 capture off", 2'd2, oldcap);
    check("R5 no flag when off", {31'd0, cflag}, 32'd0);

    // R7: CAP write ignored
    wr(2'd2, 32'h1234_5678);
    rd_chk("R7 CAP read only", 2'd2, oldcap);

    // R10: pin as count source, capture blocked
    wr(2'd0, mode_w(2'd3, 0, 1, 8'd0, 1, 1));
    wr(2'd3, 32'h0);
    for (int k = 0; k < 5; k++) begin
      pin = 1'b1; steps(2); pin = 1'b0; steps(2);
    end
    steps(3);
    rd_chk("R10 counts pin rises", 2'd3, 32'd5);
    rd_chk("R10 no capture", 2'd2, oldcap);
    check("R10 no capture flag", {31'd0, cflag}, 32'd0);

    // random phase, compared to the model
    wr(2'd1, 32'd10);
    for (int c = 0; c < 4000; c++) begin
      int r;
      logic [1:0] ri;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 4) == 0) pin = ~pin;
      if (r < 10) begin
        we = 1'b1; idx = 2'd0;
        wdata = mode_w(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                       ($urandom_range(0, 7) == 0), 8'($urandom_range(0, 3)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else if (r < 15) begin
        we = 1'b1; idx = 2'd1; wdata = $urandom_range(0, 40);
      end else if (r < 18) begin
        we = 1'b1; idx = 2'd3; wdata = $urandom;
      end else if (r < 22) begin
        we = 1'b1; idx = 2'd2; wdata = $urandom;
      end else begin
        we = 1'b0; wdata = '0;
        ri = 2'($urandom_range(0, 3));
        idx = ri; #1;
        case (ri)
          2'd0: check("R8 MODE read", rdata, model_read(ri));
          2'd1: check("R1 REF read", rdata, model_read(ri));
          2'd2: check("R5 CAP read", rdata, model_read(ri));
          default: check("R2 CNT read", rdata, model_read(ri));
        endcase
      end
      @(posedge clk); @(negedge clk);
      we = 1'b0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule